// File: doc/BRIEF.md
# Fixed-Point Fraction ALU

This block is a purely combinational arithmetic unit for a small datapath. A two-bit operation code picks one of four results: a forced zero, a wrapping sum of the two operands, a signed fractional product, or operand A copied straight through. The width `N` is a parameter and defaults to 8.

For the fractional product, both operands are read as signed two's-complement fractions in the range [-1.0, +1.0). The unit forms the full signed double-width product and returns the N-bit window that keeps the fraction aligned, which is product bits [2N-2:N-1]. The zero code reserves a slot for a load whose data arrives by another path. The result follows the inputs within the same cycle. The clock and reset ports exist only so that a checker can sample the block. They do not affect the result.

Top module: `alu_frac`

## Requirements
- R1: With opcode 2'b00 the result is all zeros, whatever the values of A and B.
- R2: With opcode 2'b01 the result is (A + B) modulo 2^N. The carry out of the top bit is dropped.
- R3: With opcode 2'b10 the result is bits [2N-2:N-1] of the signed 2N-bit product A*B, with both operands read as two's complement.
- R4: The fractional product of 0x80 by 0x80 (-1.0 times -1.0) wraps and yields 0x80. Likewise, 0x80 times 0x7F yields 0x81.
- R5: With opcode 2'b11 the result equals A, and B has no effect on it.
- R6: The result reflects the present inputs with no cycle of latency. It is the same whether reset is asserted or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the checker; not used by the datapath |
| rst_n | input | 1 | Synchronous active-low reset seen by the checker; no effect on the result |
| op_a | input | N | Operand A; fraction for the multiply |
| op_b | input | N | Operand B |
| opcode | input | 2 | 00 zero, 01 add, 10 fractional multiply, 11 pass A |
| result | output | N | Selected combinational result |

## Verification
Overflow can happen in the adder and in the multiplier in the same cycle. The bench provokes this by holding the extreme operand pair 0x80/0x80, and also 0x80/0x7F, steady while it steps the opcode from add to multiply within one cycle window. The expected add result is the truncated sum 0x00 and the expected product is the wrapped 0x80. Each opcode's value is judged against values the bench computes from plain integer arithmetic. The bench also confirms that changing B under the pass and zero codes leaves the result untouched.

// File: rtl/alu_frac_pkg.sv
package alu_frac_pkg;
    // Operation codes; the encoding is fixed by the instruction decoder upstream
    typedef enum logic [1:0] {
        OPC_CLEAR = 2'b00,
        OPC_ADD   = 2'b01,
        OPC_FMUL  = 2'b10,
        OPC_PASS  = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_wrap_add.sv
// Wrapping adder: returns a+b truncated to N bits.
// Assumes unsigned or two's-complement operands; the carry out is discarded.
module alu_wrap_add #(
    parameter int N = 8
) (
    input  logic [N-1:0] add_a,
    input  logic [N-1:0] add_b,
    output logic [N-1:0] add_sum
);
    // Sum with the carry dropped by width
    always_comb add_sum = add_a + add_b;
endmodule

// File: rtl/alu_frac_mul.sv
// Signed fractional multiplier: forms the full 2N-bit product and returns
// the fraction-aligned window [2N-2:N-1]. Assumes two's-complement Q(N-1)
// operands; -1.0 * -1.0 wraps to -1.0 by design.
module alu_frac_mul #(
    parameter int N = 8
) (
    input  logic [N-1:0] mul_a,
    input  logic [N-1:0] mul_b,
    output logic [N-1:0] mul_frac
);
    localparam int PW = 2 * N;

    logic signed [PW-1:0] prod_full;
    logic [N-1:0]         unused_prod_bits;

    // Full-width signed product
    always_comb prod_full = $signed(mul_a) * $signed(mul_b);

    // Window that keeps the binary point in place
    always_comb mul_frac = prod_full[PW-2:N-1];

    // Redundant sign bit and low fraction bits are not returned
    always_comb unused_prod_bits = {prod_full[PW-1], prod_full[N-2:0]};
endmodule

// File: rtl/alu_res_sel.sv
// Result selector: full four-way decode of the operation code.
// Assumes every code is legal; all four are covered so no default is needed.
module alu_res_sel
    import alu_frac_pkg::*;
#(
    parameter int N = 8
) (
    input  alu_op_e      sel_op,
    input  logic [N-1:0] sel_sum,
    input  logic [N-1:0] sel_frac,
    input  logic [N-1:0] sel_pass,
    output logic [N-1:0] sel_out
);
    // Pick the result that the opcode names
    always_comb begin
        unique case (sel_op)
            OPC_CLEAR: sel_out = '0;
            OPC_ADD:   sel_out = sel_sum;
            OPC_FMUL:  sel_out = sel_frac;
            OPC_PASS:  sel_out = sel_pass;
        endcase
    end
endmodule

// File: rtl/alu_frac.sv
// Top of the fixed-point fraction ALU. Purely combinational; clk and rst_n
// are present for the bound checker only and do not touch the datapath.
module alu_frac
    import alu_frac_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [1:0]   opcode,
    output logic [N-1:0] result
);
    logic [N-1:0] sum_w;
    logic [N-1:0] frac_w;
    alu_op_e      op_dec;
    logic [1:0]   unused_ctl;

    // Clock and reset only serve the checker
    always_comb unused_ctl = {clk, rst_n};

    // Map the raw code onto the operation type
    always_comb op_dec = alu_op_e'(opcode);

    alu_wrap_add #(.N(N)) u_add (
        .add_a   (op_a),
        .add_b   (op_b),
        .add_sum (sum_w)
    );

    alu_frac_mul #(.N(N)) u_mul (
        .mul_a    (op_a),
        .mul_b    (op_b),
        .mul_frac (frac_w)
    );

    alu_res_sel #(.N(N)) u_sel (
        .sel_op   (op_dec),
        .sel_sum  (sum_w),
        .sel_frac (frac_w),
        .sel_pass (op_a),
        .sel_out  (result)
    );
endmodule

// File: rtl/alu_frac_chk.sv
// Port-level checker for alu_frac, sampled on clk while out of reset.
module alu_frac_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic [1:0]   opcode,
    input logic [N-1:0] result
);
    logic signed [2*N-1:0] ref_prod;
    logic [N-1:0]          ref_sum;

    // Independent reference product and sum seen at the ports
    always_comb begin
        ref_prod = $signed(op_a) * $signed(op_b);
        ref_sum  = op_a + op_b;
    end

    assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b00) |-> (result == '0));

    assert_wrap_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b01) |-> (result == ref_sum));

    assert_frac_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b10) |-> (result == ref_prod[2*N-2:N-1]));

    assert_neg_one_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b10 && op_a == {1'b1, {(N-1){1'b0}}} && op_b == {1'b1, {(N-1){1'b0}}})
        |-> (result == {1'b1, {(N-1){1'b0}}}));

    assert_pass_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b11) |-> (result == op_a));

    assert_no_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(op_a) && $stable(op_b) && $stable(opcode)) |-> $stable(result));
endmodule

bind alu_frac alu_frac_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .opcode (opcode),
    .result (result)
);

// File: tb/alu_frac_tb.sv
module alu_frac_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [1:0] opcode = '0;
    logic [7:0] result;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alu_frac #(.N(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .result(result)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[14:7];
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h op=%b)",
                     req, result, exp, op_a, op_b, opcode);
        end
    endtask

    // Drive after the falling edge, check shortly after
    task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        opcode = op; op_a = a; op_b = b;
        #1;
    endtask

    task automatic t_reset_state;
        apply(2'b11, 8'h5A, 8'h00);
        check("R6 reset", 8'h5A);
        apply(2'b01, 8'h10, 8'h22);
        check("R6 reset", 8'h32);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_clear;
        apply(2'b00, 8'hFF, 8'hFF); check("R1", 8'h00);
        apply(2'b00, 8'h80, 8'h7F); check("R1", 8'h00);
        op_b = 8'h33; #1; check("R1", 8'h00);
    endtask

    task automatic t_add;
        apply(2'b01, 8'h12, 8'h34); check("R2", 8'h46);
        apply(2'b01, 8'hFF, 8'h01); check("R2", 8'h00);
        apply(2'b01, 8'hC8, 8'h64); check("R2", 8'h2C);
    endtask

    task automatic t_mul;
        logic [7:0] pa [6] = '{8'h40, 8'hC0, 8'h7F, 8'h20, 8'h00, 8'h99};
        logic [7:0] pb [6] = '{8'h40, 8'h40, 8'h7F, 8'hE0, 8'h55, 8'h66};
        apply(2'b10, 8'h40, 8'h40); check("R3", 8'h20);
        for (int i = 0; i < 6; i++) begin
            apply(2'b10, pa[i], pb[i]);
            check("R3", ref_mul(pa[i], pb[i]));
        end
    endtask

    task automatic t_overflow_same_cycle;
        apply(2'b01, 8'h80, 8'h80); check("R2", 8'h00);
        opcode = 2'b10; #1; check("R4", 8'h80);
        apply(2'b10, 8'h80, 8'h7F); check("R4", 8'h81);
        opcode = 2'b01; #1; check("R2", 8'hFF);
    endtask

    task automatic t_pass;
        apply(2'b11, 8'hA5, 8'h00); check("R5", 8'hA5);
        op_b = 8'hFF; #1; check("R5", 8'hA5);
        apply(2'b11, 8'h80, 8'h3C); check("R5", 8'h80);
    endtask

    task automatic t_no_latency;
        apply(2'b01, 8'h01, 8'h02); check("R6", 8'h03);
        op_a = 8'h10; #1; check("R6", 8'h12);
        opcode = 2'b11; #1; check("R6", 8'h10);
    endtask

    initial begin
        t_reset_state();
        t_clear();
        t_add();
        t_mul();
        t_overflow_same_cycle();
        t_pass();
        t_no_latency();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule